// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block produces the clock timing for an I2C controller acting as bus master. It drives a single open-drain control, `scl_pull_low`, that holds the clock line low. It also issues two one-cycle strobes, one at the first cycle of each low phase and one at the first cycle of each high phase. The byte engine uses these strobes to time its data changes and samples.

The block holds two pairs of counts, one pair for each bus speed. Each pair has a high count and a low count. The speed selector chooses which pair applies. The counts and the selector are captured only while the block is disabled, so a transfer always runs with one fixed set of timings.

A START request from the bus engine begins a hold interval, during which the engine has already dropped SDA. After the hold interval the block pulls the clock low and then alternates low and high phases until it is disabled. Each phase is its programmed count plus a fixed overhead. The low phase is counted from the first cycle in which the block pulls the line low. The high phase is counted only once the returned clock line is seen high, so a target that stretches the clock lengthens the low phase.

Top module: `i2c_scl_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `scl_pull_low`, `low_phase_stb` and `high_phase_stb` are all 0.
- R2: A value of 2 on `speed_sel` selects the fast pair (`fast_high_cnt`, `fast_low_cnt`). The values 1, 0 and 3 select the standard pair (`std_high_cnt`, `std_low_cnt`).
- R3: Each low phase keeps `scl_pull_low` at 1 for exactly low count + 1 cycles. `low_phase_stb` is 1 only in the first of those cycles.
- R4: Each high phase starts at the first clock edge that samples `scl_line` high after the release. `high_phase_stb` is 1 in the cycle after that edge. The high phase lasts high count + 8 cycles and is then followed by the next low phase.
- R5: While `scl_line` is held low by another device after the release, no high-phase strobe occurs and the block keeps the line released.
- R6: A `start_req` sampled while enabled and idle starts the START hold. `scl_pull_low` rises exactly high count + 3 cycles after that edge.
- R7: `start_req` has no effect while the block is disabled, and no effect while it is already timing a hold or clock phases.
- R8: The counts and the speed selector are captured at every clock edge where `enable` is 0. Changes made while `enable` is 1 do not affect the phase lengths.
- R9: From the first edge that samples `enable` low, the line is released and both strobes stay 0. The block waits for a new `start_req` after it is re-enabled.
- R10: After a START, low and high phases keep alternating with the same lengths for as long as the block stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; counts are captured while low |
| speed_sel | input | 2 | Speed field: 2 = fast, other values = standard |
| std_high_cnt | input | CNT_W | Standard-speed high count |
| std_low_cnt | input | CNT_W | Standard-speed low count |
| fast_high_cnt | input | CNT_W | Fast-speed high count |
| fast_low_cnt | input | CNT_W | Fast-speed low count |
| start_req | input | 1 | One-cycle START request from the bus engine |
| scl_line | input | 1 | Sampled level of the clock line |
| scl_pull_low | output | 1 | 1 = pull the clock line low |
| low_phase_stb | output | 1 | First cycle of a low phase |
| high_phase_stb | output | 1 | First cycle of a counted high phase |

## Verification
Two situations can fall in the same cycle. A `start_req` can arrive while the block is already timing a low phase, and a disable can arrive in the cycle where a released line would start a high phase. The bench pulses `start_req` at the first low cycle of every trial and checks that the low length is unchanged. It also drops `enable` exactly at the first released sample, where it checks that no high strobe appears and the line stays free. Clock stretching of random length is mixed into each trial, and the measured high length must still be counted from the first sampled-high edge.

// File: rtl/i2c_scl_timer_pkg.sv
package i2c_scl_timer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HOLD  = 3'd1,
    PH_LOW   = 3'd2,
    PH_WAITH = 3'd3,
    PH_HIGH  = 3'd4
  } phase_t;

  localparam int unsigned HOLD_EXTRA = 3;
  localparam int unsigned LOW_EXTRA  = 1;
  localparam int unsigned HIGH_EXTRA = 8;

  localparam logic [1:0] SPEED_FAST = 2'd2;

  function automatic logic speed_is_fast(input logic [1:0] sel);
    return sel == SPEED_FAST;
  endfunction

endpackage

// File: rtl/i2c_scl_cfg_latch.sv
module i2c_scl_cfg_latch
  import i2c_scl_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [1:0]       speed_sel,
  input  logic [CNT_W-1:0] std_high_cnt,
  input  logic [CNT_W-1:0] std_low_cnt,
  input  logic [CNT_W-1:0] fast_high_cnt,
  input  logic [CNT_W-1:0] fast_low_cnt,
  output logic [CNT_W-1:0] high_cnt,
  output logic [CNT_W-1:0] low_cnt
);

  logic [CNT_W-1:0] std_hi_q, std_lo_q, fast_hi_q, fast_lo_q;
  logic             fast_q;
  logic             past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      std_hi_q  <= '0;
      std_lo_q  <= '0;
      fast_hi_q <= '0;
      fast_lo_q <= '0;
      fast_q    <= 1'b0;
    end else if (!enable) begin
      std_hi_q  <= std_high_cnt;
      std_lo_q  <= std_low_cnt;
      fast_hi_q <= fast_high_cnt;
      fast_lo_q <= fast_low_cnt;
      fast_q    <= speed_is_fast(speed_sel);
    end
  end

  always_comb begin
    high_cnt = fast_q ? fast_hi_q : std_hi_q;
    low_cnt  = fast_q ? fast_lo_q : std_lo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R8: the timings in use are frozen for as long as the block stays enabled
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (enable && $past(enable)) |-> ($stable(high_cnt) && $stable(low_cnt)));

endmodule

// File: rtl/i2c_scl_phase_fsm.sv
module i2c_scl_phase_fsm
  import i2c_scl_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic             start_req,
  input  logic             scl_line,
  output logic             scl_pull_low,
  output logic             low_phase_stb,
  output logic             high_phase_stb
);

  localparam int unsigned PW = CNT_W + 4;

  phase_t        phase;
  logic [PW-1:0] cnt;
  logic [PW-1:0] hold_len, low_len, high_len;
  logic          past_ok;
  logic [PW-1:0] low_run;

  always_comb begin
    hold_len = PW'(high_cnt) + PW'(HOLD_EXTRA);
    low_len  = PW'(low_cnt)  + PW'(LOW_EXTRA);
    high_len = PW'(high_cnt) + PW'(HIGH_EXTRA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase          <= PH_IDLE;
      cnt            <= '0;
      scl_pull_low   <= 1'b0;
      low_phase_stb  <= 1'b0;
      high_phase_stb <= 1'b0;
    end else begin
      low_phase_stb  <= 1'b0;
      high_phase_stb <= 1'b0;
      if (!enable) begin
        phase        <= PH_IDLE;
        cnt          <= '0;
        scl_pull_low <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: begin
            if (start_req) begin
              phase <= PH_HOLD;
              cnt   <= PW'(1);
            end
          end
          PH_HOLD: begin
            if (cnt == hold_len) begin
              phase         <= PH_LOW;
              cnt           <= PW'(1);
              scl_pull_low  <= 1'b1;
              low_phase_stb <= 1'b1;
            end else begin
              cnt <= cnt + PW'(1);
            end
          end
          PH_LOW: begin
            if (cnt == low_len) begin
              phase        <= PH_WAITH;
              cnt          <= '0;
              scl_pull_low <= 1'b0;
            end else begin
              cnt <= cnt + PW'(1);
            end
          end
          PH_WAITH: begin
            if (scl_line) begin
              phase          <= PH_HIGH;
              cnt            <= PW'(1);
              high_phase_stb <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (cnt == high_len) begin
              phase         <= PH_LOW;
              cnt           <= PW'(1);
              scl_pull_low  <= 1'b1;
              low_phase_stb <= 1'b1;
            end else begin
              cnt <= cnt + PW'(1);
            end
          end
          default: begin
            phase        <= PH_IDLE;
            cnt          <= '0;
            scl_pull_low <= 1'b0;
          end
        endcase
      end
    end
  end

  // Observation counter: length of the current pull-low run
  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      low_run <= '0;
    end else begin
      past_ok <= 1'b1;
      low_run <= scl_pull_low ? low_run + PW'(1) : '0;
    end
  end

  // R3: a pull-low run that ends normally lasts low count + 1 cycles
  assert_low_len_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($fell(scl_pull_low) && $past(enable)) |-> (low_run == low_len));

  // R3: the low strobe marks the rising edge of the pull
  assert_low_stb_edge_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
    low_phase_stb |-> (scl_pull_low && !$past(scl_pull_low)));

  // R5: a high phase only begins once the line was seen high
  assert_high_waits_line_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    high_phase_stb |-> ($past(scl_line) && !scl_pull_low));

  // R9: disabled means released and silent
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(enable) |-> (!scl_pull_low && !low_phase_stb && !high_phase_stb));

  // R4: strobes never coincide
  assert_stb_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({low_phase_stb, high_phase_stb}));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [1:0]       speed_sel,
  input  logic [CNT_W-1:0] std_high_cnt,
  input  logic [CNT_W-1:0] std_low_cnt,
  input  logic [CNT_W-1:0] fast_high_cnt,
  input  logic [CNT_W-1:0] fast_low_cnt,
  input  logic             start_req,
  input  logic             scl_line,
  output logic             scl_pull_low,
  output logic             low_phase_stb,
  output logic             high_phase_stb
);

  logic [CNT_W-1:0] sel_high, sel_low;

  i2c_scl_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .speed_sel     (speed_sel),
    .std_high_cnt  (std_high_cnt),
    .std_low_cnt   (std_low_cnt),
    .fast_high_cnt (fast_high_cnt),
    .fast_low_cnt  (fast_low_cnt),
    .high_cnt      (sel_high),
    .low_cnt       (sel_low)
  );

  i2c_scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .enable         (enable),
    .high_cnt       (sel_high),
    .low_cnt        (sel_low),
    .start_req      (start_req),
    .scl_line       (scl_line),
    .scl_pull_low   (scl_pull_low),
    .low_phase_stb  (low_phase_stb),
    .high_phase_stb (high_phase_stb)
  );

  // R1: outputs quiet in the cycle following a reset edge
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!scl_pull_low && !low_phase_stb && !high_phase_stb));

endmodule

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [1:0]    speed_sel = 2'd1;
  logic [CW-1:0] std_hi = '0, std_lo = '0, fast_hi = '0, fast_lo = '0;
  logic          start_req = 1'b0;
  logic          stretch = 1'b0;
  logic          scl_line;
  logic          scl_pull_low, low_stb, high_stb;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  assign scl_line = !scl_pull_low && !stretch;

  i2c_scl_timer #(.CNT_W(CW)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .enable         (enable),
    .speed_sel      (speed_sel),
    .std_high_cnt   (std_hi),
    .std_low_cnt    (std_lo),
    .fast_high_cnt  (fast_hi),
    .fast_low_cnt   (fast_lo),
    .start_req      (start_req),
    .scl_line       (scl_line),
    .scl_pull_low   (scl_pull_low),
    .low_phase_stb  (low_stb),
    .high_phase_stb (high_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: pair chosen by speed field
  function automatic int pick(input int sp, input int s, input int f);
    return (sp == 2) ? f : s;
  endfunction

  task automatic trial(input int sp, input int sh, input int sl, input int fh,
                       input int fl, input int stretch_cyc, input bit scramble);
    int eh, el, n, bad;
    eh = pick(sp, sh, fh);
    el = pick(sp, sl, fl);
    @(negedge clk);
    enable = 1'b0;
    speed_sel = 2'(sp); std_hi = CW'(sh); std_lo = CW'(sl);
    fast_hi = CW'(fh); fast_lo = CW'(fl);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    if (scramble) begin
      // R8: changes while enabled must not be used
      speed_sel = 2'($urandom % 4);
      std_hi = CW'($urandom % 30); std_lo = CW'($urandom % 30);
      fast_hi = CW'($urandom % 30); fast_lo = CW'($urandom % 30);
    end
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    n = 0;
    while (!scl_pull_low) begin n++; @(negedge clk); end
    chk(scramble ? "R6/R8 start hold" : "R6/R2 start hold", n, eh + 3);
    chk("R3 low strobe at first low cycle", int'(low_stb), 1);
    stretch = 1'b1;
    n = 0;
    while (scl_pull_low) begin
      start_req = (n == 0); // R7: request while busy
      n++;
      @(negedge clk);
    end
    start_req = 1'b0;
    chk("R3/R7 low length", n, el + 1);
    bad = 0;
    repeat (stretch_cyc) begin
      if (high_stb || scl_pull_low) bad++;
      @(negedge clk);
    end
    chk("R5 stretched line holds off high phase", bad, 0);
    stretch = 1'b0;
    @(negedge clk);
    chk("R4 high strobe after line seen high", int'(high_stb), 1);
    n = 0;
    while (!scl_pull_low) begin n++; @(negedge clk); end
    chk("R4 high length", n, eh + 8);
    chk("R10 next low strobe", int'(low_stb), 1);
    n = 0;
    while (scl_pull_low) begin n++; @(negedge clk); end
    chk("R10 repeated low length", n, el + 1);
    // R9: disable at the very cycle a high phase would be picked up
    enable = 1'b0;
    bad = 0;
    repeat (eh + el + 12) begin
      @(negedge clk);
      if (scl_pull_low || low_stb || high_stb) bad++;
    end
    chk("R9 disabled stays released and silent", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    enable = 1'b1;
    chk("R1 pull during reset", int'(scl_pull_low), 0);
    chk("R1 strobes during reset", int'(low_stb || high_stb), 0);
    rst = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    chk("R1 pull after reset", int'(scl_pull_low), 0);

    // R7: request while disabled is dropped; enabling alone does nothing
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (scl_pull_low || low_stb || high_stb) bad++;
    end
    chk("R7 request while disabled ignored", bad, 0);

    // Directed corners
    trial(2, 9, 9, 0, 0, 0, 1'b0);    // R2 fast pair, minimum counts
    trial(1, 0, 0, 7, 7, 1, 1'b0);    // R2 standard, minimum counts
    trial(0, 11, 4, 2, 20, 3, 1'b0);  // R2 value 0 -> standard
    trial(3, 5, 13, 17, 1, 2, 1'b0);  // R2 value 3 -> standard
    trial(1, 25, 30, 3, 3, 6, 1'b1);  // R8 scramble while enabled

    // Constrained random
    for (int t = 0; t < 16; t++) begin
      trial(int'($urandom % 4), int'($urandom % 24), int'($urandom % 24),
            int'($urandom % 24), int'($urandom % 24), int'($urandom % 8),
            1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule